// File: doc/BRIEF.md
# Privileged Trap and Status Controller

This block keeps a processor's privileged state: a status word, the trap cause, the saved trap PC, the faulting address, a kernel scratch word, three jump targets for traps, and a page-table context word. When the pipeline raises a trap, the controller pushes the mode and interrupt-enable pair onto a three-deep stack held in the status word. It enters kernel mode with interrupts off, records the cause, the PC and (for address faults) the address, and gives the pipeline the next PC. On a return-from-trap it pops the stack and sends the pipeline back to the saved PC.

Software reaches every register through one write port and one read port. Each port carries a 6-bit extended register number. Reads are combinational. Trap and return redirects come out in the same cycle as the request, and the register updates show one clock later.

Top module: `trap_ctl_unit`

## Requirements
- R1: After reset the status reads 0x01 (kernel mode, interrupts off, all stacked and cache bits 0) and every other register reads 0. No redirect is requested.
- R2: The register numbers are 0x00 status, 0x01 cause, 0x02 trap PC, 0x03 faulting address, 0x04 scratch and 0x15 context. The trap targets are 0x05 general, 0x06 TLB miss and 0x07 firmware call. Status keeps only write bits 7:0, cause keeps only bits 3:0, the faulting address ignores writes, and unmapped numbers read 0.
- R3: On a trap, status bits 5:2 take the old bits 3:0, bit 0 becomes 1 (kernel), bit 1 becomes 0, and bits 7:6 keep their value.
- R4: A trap stores its PC in the trap PC register and its cause in the cause register. It stores its address in the faulting-address register only for causes 3 to 7 (TLB miss, TLB modify, TLB invalid, misaligned read, misaligned write).
- R5: A trap raises `redirect_valid_o` in the same cycle. `redirect_pc_o` is the TLB-miss target for cause 3, the firmware-call target for a legal firmware call, and the general target for every other trap.
- R6: Cause 2 with `trap_fw_i`=1 is a firmware call. In kernel mode it records cause 2. In user mode it records cause 11 (permission) and goes to the general target. Cause 2 with `trap_fw_i`=0 is a kernel call and always records cause 2.
- R7: A return-from-trap raises `redirect_valid_o` with `redirect_pc_o` equal to the trap PC register. Status bits 3:0 take the old bits 5:2, and bits 7:4 keep their value.
- R8: The context register reads the stored page-table base in bits 31:21, faulting-address bits 30:12 in bits 20:2, and 0 in bits 1:0. A write to it keeps only bits 31:21.
- R9: When a trap and a return arrive in the same cycle, the trap wins. A register write that arrives in the same cycle as a trap or a return is discarded.
- R10: `kernel_mode_o` and `intr_en_o` show status bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_num_i | input | 6 | Register number to write |
| wr_data_i | input | 32 | Write data |
| rd_num_i | input | 6 | Register number to read |
| rd_data_o | output | 32 | Read data (combinational) |
| trap_i | input | 1 | Trap request |
| trap_cause_i | input | 4 | Cause code of the trap |
| trap_fw_i | input | 1 | For cause 2: 1 = firmware call, 0 = kernel call |
| trap_pc_i | input | 32 | PC of the faulting instruction |
| trap_addr_i | input | 32 | Faulting address |
| rft_i | input | 1 | Return-from-trap request |
| redirect_valid_o | output | 1 | Next PC is supplied this cycle |
| redirect_pc_o | output | 32 | Next PC |
| kernel_mode_o | output | 1 | Current mode (1 = kernel) |
| intr_en_o | output | 1 | Current interrupt enable |

## Verification
Three functions can meet in one cycle: a trap, a return-from-trap and a software register write. The bench drives a trap, a return and a scratch write together. It checks that the redirect goes to the general target and not to the saved PC, and that the status shows a push and not a pop. It then reads back the scratch register to confirm that its value did not change. A second case pairs a return with a status write, and the bench checks that the popped value wins over the written value.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;
  localparam int XLEN   = 32;
  localparam int NUM_W  = 6;
  localparam int STAT_W = 8;
  localparam int CAUSE_W = 4;

  typedef enum logic [3:0] {
    C_NONE     = 4'd0,
    C_EXT      = 4'd1,
    C_CALL     = 4'd2,
    C_TLB_MISS = 4'd3,
    C_TLB_MOD  = 4'd4,
    C_TLB_INV  = 4'd5,
    C_MIS_RD   = 4'd6,
    C_MIS_WR   = 4'd7,
    C_FETCH    = 4'd8,
    C_DATA     = 4'd9,
    C_DIV0     = 4'd10,
    C_PERM     = 4'd11,
    C_OPCODE   = 4'd12
  } cause_e;

  localparam logic [NUM_W-1:0] XR_STATUS  = 6'h00;
  localparam logic [NUM_W-1:0] XR_CAUSE   = 6'h01;
  localparam logic [NUM_W-1:0] XR_EPC     = 6'h02;
  localparam logic [NUM_W-1:0] XR_BADADDR = 6'h03;
  localparam logic [NUM_W-1:0] XR_SCRATCH = 6'h04;
  localparam logic [NUM_W-1:0] XR_VEC_GEN = 6'h05;
  localparam logic [NUM_W-1:0] XR_VEC_TLB = 6'h06;
  localparam logic [NUM_W-1:0] XR_VEC_FW  = 6'h07;
  localparam logic [NUM_W-1:0] XR_CONTEXT = 6'h15;

  function automatic logic is_addr_fault(input logic [3:0] c);
    return (c >= C_TLB_MISS) && (c <= C_MIS_WR);
  endfunction
endpackage

// File: rtl/trap_mode_stack.sv
module trap_mode_stack #(
  parameter int STAT_W = trap_ctl_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              rft_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int STACK_W = 6;
  localparam logic [STAT_W-1:0] RESET_VAL = STAT_W'(1);

  logic [STAT_W-1:0] stat_q, stat_d;
  logic              stat_en;

  always_comb begin
    stat_en = trap_i | rft_i | wr_i;
    stat_d  = stat_q;
    if (trap_i) begin
      stat_d[STACK_W-1:2] = stat_q[STACK_W-3:0];
      stat_d[1]           = 1'b0;
      stat_d[0]           = 1'b1;
    end else if (rft_i) begin
      stat_d[STACK_W-3:0] = stat_q[STACK_W-1:2];
    end else if (wr_i) begin
      stat_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= RESET_VAL;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  assert_push_kernel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (stat_q[0] && !stat_q[1]
                && stat_q[5:2] == $past(stat_q[3:0])
                && stat_q[7:6] == $past(stat_q[7:6])));

  assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rft_i && !trap_i) |=> (stat_q[3:0] == $past(stat_q[5:2])
                            && stat_q[7:4] == $past(stat_q[7:4])));
endmodule

// File: rtl/trap_route.sv
module trap_route #(
  parameter int XLEN = trap_ctl_pkg::XLEN
) (
  input  logic            kernel_i,
  input  logic            trap_i,
  input  logic [3:0]      cause_i,
  input  logic            fw_i,
  input  logic            rft_i,
  input  logic [XLEN-1:0] vec_gen_i,
  input  logic [XLEN-1:0] vec_tlb_i,
  input  logic [XLEN-1:0] vec_fw_i,
  input  logic [XLEN-1:0] epc_i,
  output logic [3:0]      cause_eff_o,
  output logic            latch_addr_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  import trap_ctl_pkg::*;

  logic            fw_call;
  logic            fw_legal;
  logic [XLEN-1:0] vec_sel;

  always_comb begin
    fw_call     = (cause_i == C_CALL) && fw_i;
    fw_legal    = fw_call && kernel_i;
    cause_eff_o = (fw_call && !kernel_i) ? C_PERM : cause_i;
    latch_addr_o = is_addr_fault(cause_eff_o);
    if (cause_eff_o == C_TLB_MISS) vec_sel = vec_tlb_i;
    else if (fw_legal)             vec_sel = vec_fw_i;
    else                           vec_sel = vec_gen_i;
    redirect_valid_o = trap_i | rft_i;
    redirect_pc_o    = trap_i ? vec_sel : epc_i;
  end
endmodule

// File: rtl/trap_ctl_regs.sv
module trap_ctl_regs #(
  parameter int XLEN       = trap_ctl_pkg::XLEN,
  parameter int NUM_W      = trap_ctl_pkg::NUM_W,
  parameter int STAT_W     = trap_ctl_pkg::STAT_W,
  parameter int CAUSE_W    = trap_ctl_pkg::CAUSE_W,
  parameter int PAGE_SHIFT = 12,
  parameter int CTX_VPN_W  = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NUM_W-1:0]   wr_num_i,
  input  logic [XLEN-1:0]    wr_data_i,
  input  logic [NUM_W-1:0]   rd_num_i,
  output logic [XLEN-1:0]    rd_data_o,
  input  logic [STAT_W-1:0]  status_i,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] cause_eff_i,
  input  logic               latch_addr_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic [XLEN-1:0]    trap_addr_i,
  output logic [XLEN-1:0]    vec_gen_o,
  output logic [XLEN-1:0]    vec_tlb_o,
  output logic [XLEN-1:0]    vec_fw_o,
  output logic [XLEN-1:0]    epc_o
);
  import trap_ctl_pkg::*;

  localparam int CTX_LSB      = 2;
  localparam int CTX_BASE_LSB = CTX_LSB + CTX_VPN_W;
  localparam int CTX_BASE_W   = XLEN - CTX_BASE_LSB;

  logic [CAUSE_W-1:0]    cause_q, cause_d;
  logic [XLEN-1:0]       epc_q, epc_d, bad_q, bad_d, scr_q, scr_d;
  logic [XLEN-1:0]       vgen_q, vgen_d, vtlb_q, vtlb_d, vfw_q, vfw_d;
  logic [CTX_BASE_W-1:0] base_q, base_d;
  logic cause_en, epc_en, bad_en, scr_en, vgen_en, vtlb_en, vfw_en, base_en;
  logic [XLEN-1:0]       ctx_val;

  always_comb begin
    cause_en = trap_i | (wr_en_i && wr_num_i == XR_CAUSE);
    cause_d  = trap_i ? cause_eff_i : wr_data_i[CAUSE_W-1:0];
    epc_en   = trap_i | (wr_en_i && wr_num_i == XR_EPC);
    epc_d    = trap_i ? trap_pc_i : wr_data_i;
    bad_en   = trap_i && latch_addr_i;
    bad_d    = trap_addr_i;
    scr_en   = wr_en_i && wr_num_i == XR_SCRATCH;
    scr_d    = wr_data_i;
    vgen_en  = wr_en_i && wr_num_i == XR_VEC_GEN;
    vgen_d   = wr_data_i;
    vtlb_en  = wr_en_i && wr_num_i == XR_VEC_TLB;
    vtlb_d   = wr_data_i;
    vfw_en   = wr_en_i && wr_num_i == XR_VEC_FW;
    vfw_d    = wr_data_i;
    base_en  = wr_en_i && wr_num_i == XR_CONTEXT;
    base_d   = wr_data_i[XLEN-1:CTX_BASE_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      bad_q   <= '0;
      scr_q   <= '0;
      vgen_q  <= '0;
      vtlb_q  <= '0;
      vfw_q   <= '0;
      base_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (epc_en)   epc_q   <= epc_d;
      if (bad_en)   bad_q   <= bad_d;
      if (scr_en)   scr_q   <= scr_d;
      if (vgen_en)  vgen_q  <= vgen_d;
      if (vtlb_en)  vtlb_q  <= vtlb_d;
      if (vfw_en)   vfw_q   <= vfw_d;
      if (base_en)  base_q  <= base_d;
    end
  end

  assign ctx_val = {base_q, bad_q[PAGE_SHIFT+CTX_VPN_W-1:PAGE_SHIFT], {CTX_LSB{1'b0}}};

  always_comb begin
    case (rd_num_i)
      XR_STATUS:  rd_data_o = XLEN'(status_i);
      XR_CAUSE:   rd_data_o = XLEN'(cause_q);
      XR_EPC:     rd_data_o = epc_q;
      XR_BADADDR: rd_data_o = bad_q;
      XR_SCRATCH: rd_data_o = scr_q;
      XR_VEC_GEN: rd_data_o = vgen_q;
      XR_VEC_TLB: rd_data_o = vtlb_q;
      XR_VEC_FW:  rd_data_o = vfw_q;
      XR_CONTEXT: rd_data_o = ctx_val;
      default:    rd_data_o = '0;
    endcase
  end

  assign vec_gen_o = vgen_q;
  assign vec_tlb_o = vtlb_q;
  assign vec_fw_o  = vfw_q;
  assign epc_o     = epc_q;

  assert_epc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (epc_q == $past(trap_pc_i) && cause_q == $past(cause_eff_i)));

  assert_badaddr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_i && latch_addr_i) |=> $stable(bad_q));

  assert_scratch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_num_i == XR_SCRATCH) |=> $stable(scr_q));
endmodule

// File: rtl/trap_ctl_unit.sv
module trap_ctl_unit #(
  parameter int XLEN  = trap_ctl_pkg::XLEN,
  parameter int NUM_W = trap_ctl_pkg::NUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [NUM_W-1:0] wr_num_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [NUM_W-1:0] rd_num_i,
  output logic [XLEN-1:0]  rd_data_o,
  input  logic             trap_i,
  input  logic [3:0]       trap_cause_i,
  input  logic             trap_fw_i,
  input  logic [XLEN-1:0]  trap_pc_i,
  input  logic [XLEN-1:0]  trap_addr_i,
  input  logic             rft_i,
  output logic             redirect_valid_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             kernel_mode_o,
  output logic             intr_en_o
);
  import trap_ctl_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_ok;
  logic [STAT_W-1:0] status;
  logic [3:0]        cause_eff;
  logic              latch_addr;
  logic [XLEN-1:0]   vec_gen, vec_tlb, vec_fw, epc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_ok = wr_en_i & ~trap_i & ~rft_i;

  trap_mode_stack #(.STAT_W(STAT_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trap_i    (trap_i),
    .rft_i     (rft_i),
    .wr_i      (wr_ok && wr_num_i == XR_STATUS),
    .wr_data_i (wr_data_i[STAT_W-1:0]),
    .status_o  (status)
  );

  trap_route #(.XLEN(XLEN)) u_route (
    .kernel_i         (status[0]),
    .trap_i           (trap_i),
    .cause_i          (trap_cause_i),
    .fw_i             (trap_fw_i),
    .rft_i            (rft_i),
    .vec_gen_i        (vec_gen),
    .vec_tlb_i        (vec_tlb),
    .vec_fw_i         (vec_fw),
    .epc_i            (epc),
    .cause_eff_o      (cause_eff),
    .latch_addr_o     (latch_addr),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
  );

  trap_ctl_regs #(.XLEN(XLEN), .NUM_W(NUM_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_en_i      (wr_ok),
    .wr_num_i     (wr_num_i),
    .wr_data_i    (wr_data_i),
    .rd_num_i     (rd_num_i),
    .rd_data_o    (rd_data_o),
    .status_i     (status),
    .trap_i       (trap_i),
    .cause_eff_i  (cause_eff),
    .latch_addr_i (latch_addr),
    .trap_pc_i    (trap_pc_i),
    .trap_addr_i  (trap_addr_i),
    .vec_gen_o    (vec_gen),
    .vec_tlb_o    (vec_tlb),
    .vec_fw_o     (vec_fw),
    .epc_o        (epc)
  );

  assign kernel_mode_o = status[0];
  assign intr_en_o     = status[1];

  assert_tlb_target_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (trap_i && trap_cause_i == C_TLB_MISS) |-> (redirect_valid_o && redirect_pc_o == vec_tlb));

  assert_user_fw_perm_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (trap_i && trap_cause_i == C_CALL && trap_fw_i && !kernel_mode_o)
      |-> (cause_eff == C_PERM && redirect_pc_o == vec_gen));

  assert_rft_target_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rft_i && !trap_i) |-> (redirect_valid_o && redirect_pc_o == epc));

  assert_trap_enters_kernel_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    trap_i |=> (kernel_mode_o && !intr_en_o));
endmodule

// File: tb/trap_ctl_unit_tb_top.sv
module trap_ctl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_num;
  logic [31:0] wr_data;
  logic [5:0]  rd_num;
  logic [31:0] rd_data;
  logic        trap;
  logic [3:0]  cause;
  logic        fw;
  logic [31:0] tpc, taddr;
  logic        rft;
  logic        rvalid;
  logic [31:0] rpc;
  logic        kmode, ien;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  localparam logic [31:0] VGEN = 32'h8000_0100;
  localparam logic [31:0] VTLB = 32'h8000_0000;
  localparam logic [31:0] VFW  = 32'hBFC0_0200;

  always #5 clk = ~clk;

  trap_ctl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_num_i(wr_num), .wr_data_i(wr_data),
    .rd_num_i(rd_num), .rd_data_o(rd_data), .trap_i(trap), .trap_cause_i(cause),
    .trap_fw_i(fw), .trap_pc_i(tpc), .trap_addr_i(taddr), .rft_i(rft),
    .redirect_valid_o(rvalid), .redirect_pc_o(rpc), .kernel_mode_o(kmode), .intr_en_o(ien)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdreg(input logic [5:0] n, output logic [31:0] v);
    rd_num = n;
    #1;
    v = rd_data;
  endtask

  task automatic chkreg(input string tag, input logic [5:0] n, input logic [31:0] exp);
    logic [31:0] v;
    rdreg(n, v);
    chk(tag, v, exp);
  endtask

  task automatic mtex(input logic [5:0] n, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = n; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(input string tag, input logic [3:0] c, input logic f,
                      input logic [31:0] pc, input logic [31:0] a, input logic [31:0] exp_pc);
    @(negedge clk);
    trap = 1'b1; cause = c; fw = f; tpc = pc; taddr = a;
    #1;
    chk({tag, " redirect valid"}, {31'd0, rvalid}, 32'd1);
    chk({tag, " redirect pc"}, rpc, exp_pc);
    @(negedge clk);
    trap = 1'b0;
  endtask

  task automatic do_rft(input string tag, input logic [31:0] exp_pc);
    @(negedge clk);
    rft = 1'b1;
    #1;
    chk({tag, " rft valid"}, {31'd0, rvalid}, 32'd1);
    chk({tag, " rft pc"}, rpc, exp_pc);
    @(negedge clk);
    rft = 1'b0;
  endtask

  task automatic t_reset;
    chkreg("R1 status", 6'h00, 32'h01);
    chkreg("R1 scratch", 6'h04, 32'h0);
    chkreg("R1 epc", 6'h02, 32'h0);
    chkreg("R1 context", 6'h15, 32'h0);
    chk("R1 no redirect", {31'd0, rvalid}, 32'd0);
    chk("R10 reset kernel", {30'd0, ien, kmode}, 32'h1);
  endtask

  task automatic t_map;
    mtex(6'h04, 32'h1234_5678);
    mtex(6'h05, VGEN);
    mtex(6'h06, VTLB);
    mtex(6'h07, VFW);
    mtex(6'h02, 32'hCAFE_0000);
    mtex(6'h01, 32'hFFFF_FFF7);
    mtex(6'h03, 32'hFFFF_FFFF);
    mtex(6'h00, 32'hABCD_00C2);
    chkreg("R2 scratch", 6'h04, 32'h1234_5678);
    chkreg("R2 vec gen", 6'h05, VGEN);
    chkreg("R2 vec tlb", 6'h06, VTLB);
    chkreg("R2 vec fw", 6'h07, VFW);
    chkreg("R2 epc", 6'h02, 32'hCAFE_0000);
    chkreg("R2 cause low bits", 6'h01, 32'h7);
    chkreg("R2 badaddr read-only", 6'h03, 32'h0);
    chkreg("R2 status low byte", 6'h00, 32'hC2);
    chkreg("R2 unmapped", 6'h3F, 32'h0);
    chk("R10 user ie", {30'd0, ien, kmode}, 32'h2);
  endtask

  task automatic t_trap_rft;
    fire("R5 external", 4'd1, 1'b0, 32'h1000, 32'hDEAD_0000, VGEN);
    chkreg("R3 push status", 6'h00, 32'hC9);
    chkreg("R4 cause", 6'h01, 32'd1);
    chkreg("R4 epc", 6'h02, 32'h1000);
    chkreg("R4 badaddr kept on cause 1", 6'h03, 32'h0);
    chk("R10 after trap", {30'd0, ien, kmode}, 32'h1);
    do_rft("R7", 32'h1000);
    chkreg("R7 pop status", 6'h00, 32'hC2);
  endtask

  task automatic t_nested;
    logic [31:0] a;
    a = 32'h1234_5678;
    fire("R5 misaligned", 4'd6, 1'b0, 32'h2000, 32'h0000_3002, VGEN);
    chkreg("R3 first push", 6'h00, 32'hC9);
    chkreg("R4 badaddr cause 6", 6'h03, 32'h0000_3002);
    fire("R5 tlb miss", 4'd3, 1'b0, 32'h2004, a, VTLB);
    chkreg("R3 second push", 6'h00, 32'hE5);
    chkreg("R4 badaddr cause 3", 6'h03, a);
    mtex(6'h15, 32'hFFFF_FFFF);
    chkreg("R8 context", 6'h15, {11'h7FF, a[30:12], 2'b00});
    do_rft("R7 inner", 32'h2004);
    chkreg("R7 first pop", 6'h00, 32'hE9);
    do_rft("R7 outer", 32'h2004);
    chkreg("R7 second pop keeps 5:4", 6'h00, 32'hEA);
    fire("R5 div0", 4'd10, 1'b0, 32'h3000, 32'h55, VGEN);
    chkreg("R4 badaddr kept on cause 10", 6'h03, a);
    chkreg("R4 cause 10", 6'h01, 32'd10);
  endtask

  task automatic t_calls;
    mtex(6'h00, 32'h01);
    fire("R5 fw call kernel", 4'd2, 1'b1, 32'h4000, 32'h0, VFW);
    chkreg("R6 fw kernel cause", 6'h01, 32'd2);
    mtex(6'h00, 32'h00);
    fire("R6 fw call user", 4'd2, 1'b1, 32'h4100, 32'h0, VGEN);
    chkreg("R6 fw user cause", 6'h01, 32'd11);
    mtex(6'h00, 32'h00);
    fire("R6 kernel call user", 4'd2, 1'b0, 32'h4200, 32'h0, VGEN);
    chkreg("R6 kcall cause", 6'h01, 32'd2);
  endtask

  task automatic t_collide;
    mtex(6'h04, 32'h55);
    mtex(6'h00, 32'h02);
    @(negedge clk);
    trap = 1'b1; cause = 4'd1; fw = 1'b0; tpc = 32'h5000; taddr = 32'h0;
    rft = 1'b1; wr_en = 1'b1; wr_num = 6'h04; wr_data = 32'hAA;
    #1;
    chk("R9 trap beats rft pc", rpc, VGEN);
    @(negedge clk);
    trap = 1'b0; rft = 1'b0; wr_en = 1'b0;
    chkreg("R9 write dropped", 6'h04, 32'h55);
    chkreg("R9 push not pop", 6'h00, 32'h09);
    chkreg("R9 epc from trap", 6'h02, 32'h5000);
    @(negedge clk);
    rft = 1'b1; wr_en = 1'b1; wr_num = 6'h00; wr_data = 32'h77;
    @(negedge clk);
    rft = 1'b0; wr_en = 1'b0;
    chkreg("R9 rft beats write", 6'h00, 32'h02);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_num = '0; wr_data = '0; rd_num = '0;
    trap = 1'b0; cause = '0; fw = 1'b0; tpc = '0; taddr = '0; rft = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_map;
    t_trap_rft;
    t_nested;
    t_calls;
    t_collide;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule